// File: doc/BRIEF.md
# Programmable Bit-Clock and Word-Clock Generator

This block derives the two timing signals of a serial audio port from one master clock: a bit clock at the master rate divided by a programmable integer, and a word clock (frame sync) whose period is a programmable number of bit clocks. The word clock is low for the first half of each frame and high for the second half. A programmable lead, counted in master-clock periods, moves every word-clock edge earlier than the bit-clock edge it belongs to. Setting the lead to half the divisor puts the word-clock edges on the falling edge of the bit clock. For example, a divisor of 2 with a lead of 1 gives 12.288 MHz from 24.576 MHz with edges on the falling edge.

An I2S framing option moves the word clock one further full bit-clock period earlier, so that it changes one bit before the frame starts. All state is registered on the rising edge of the master clock, and no logic uses the falling edge. This creates a limit at a divisor of 1. There the master clock is passed straight out as the bit clock, a half-period lead does not exist, and the word clock changes on the rising edge of the bit clock. The block raises a non-compliance flag when that setting is combined with I2S framing.

The configuration is sampled when the block starts and again at each frame wrap, and is held for the rest of the frame. Software can therefore change it at any time without producing a short pulse.

Top module: `frame_clock_gen`

## Requirements
- R1: While `rst` is high, or in the cycle after `en` was seen low, `bclk_o`, `fsync_o` and `nocomp_o` are all 0. After `en` rises, the first frame starts at position 0 in the next cycle.
- R2: For an active divisor D of 2 or more, `bclk_o` repeats every D master cycles. It is high for ceil(D/2) cycles and low for floor(D/2) cycles, and it rises at the first cycle of each bit.
- R3: For an active divisor of 1, `bclk_o` follows the master clock: it is high while `clk` is high and low while `clk` is low.
- R4: A frame is F bit clocks long, which is D*F master cycles. With a lead of 0 and I2S framing off, `fsync_o` is 0 over positions 0 to D*F/2-1 and 1 over the rest, and it changes in the same cycle that `bclk_o` rises.
- R5: With a lead of N, `fsync_o` at frame position p equals the R4 value at position (p+N) mod D*F, so every edge comes N master cycles early.
- R6: A requested lead of D or more is used as D-1.
- R7: With I2S framing on (`cfg_i2s`=1), the word clock leads by a further D master cycles, one bit clock, added to the lead of R5.
- R8: `nocomp_o` is 1 exactly while the block is running with an active divisor of 1 and I2S framing on.
- R9: Changes to the configuration inputs take effect only at the first cycle of a frame (start or wrap). Within a frame the bit clock and word clock keep the settings the frame started with.
- R10: A divisor input of 0 is used as 1. An odd frame length is rounded down to the even value below it, and any length below 2 is used as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all state on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low stops and clears the outputs |
| cfg_bdiv | input | 6 | Bit-clock divisor D in master cycles |
| cfg_flen | input | 8 | Frame length F in bit clocks |
| cfg_phase | input | 6 | Word-clock lead N in master cycles |
| cfg_i2s | input | 1 | Adds one bit clock of lead for I2S framing |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Word clock / frame sync |
| nocomp_o | output | 1 | High when the setting cannot put word-clock edges on bit-clock falling edges |

## Verification
The properties assume that the configuration used inside a frame is the one sampled at its start. They also assume that `en` is a plain synchronous level, with no relation required between it and the frame position. The stimulus changes the configuration inputs at arbitrary cycles, mid-frame as well as at boundaries. It includes out-of-range values: a divisor of 0, odd and tiny frame lengths, and leads at or above the divisor. This exercises the sanitising and deferred loading rather than avoiding them. `en` is dropped at random moments, including mid-frame, because the stop path must clear the outputs from any position.

// File: rtl/fcg_pkg.sv
`timescale 1ns/1ps
package fcg_pkg;
    localparam int BDIV_W = 6;
    localparam int FLEN_W = 8;
    localparam int POS_W  = BDIV_W + FLEN_W;
    localparam int LEAD_W = BDIV_W + 1;

    typedef struct packed {
        logic [BDIV_W-1:0] bdiv;
        logic [FLEN_W-1:0] flen;
        logic [BDIV_W-1:0] ph;
        logic              i2s;
        logic [POS_W-1:0]  period;
        logic [LEAD_W-1:0] lead;
    } act_t;

    typedef struct packed {
        logic              run;
        logic [POS_W-1:0]  pos;
        logic [BDIV_W-1:0] cnt;
        act_t              act;
    } tb_t;

    typedef struct packed {
        logic bclk;
        logic fs;
        logic nc;
        logic pass;
    } out_t;
endpackage

// File: rtl/fcg_cfg_clean.sv
`timescale 1ns/1ps
module fcg_cfg_clean
    import fcg_pkg::*;
(
    input  logic [BDIV_W-1:0] raw_bdiv,
    input  logic [FLEN_W-1:0] raw_flen,
    input  logic [BDIV_W-1:0] raw_ph,
    input  logic              raw_i2s,
    output act_t              cand
);
    logic [BDIV_W-1:0] b_d;
    logic [BDIV_W-1:0] p_d;
    logic [FLEN_W-1:0] f_d;

    always_comb begin
        b_d = (raw_bdiv == '0) ? BDIV_W'(1) : raw_bdiv;
        f_d = {raw_flen[FLEN_W-1:1], 1'b0};
        if (f_d < FLEN_W'(2)) begin
            f_d = FLEN_W'(2);
        end
        p_d = (raw_ph >= b_d) ? (b_d - BDIV_W'(1)) : raw_ph;

        cand.bdiv   = b_d;
        cand.flen   = f_d;
        cand.ph     = p_d;
        cand.i2s    = raw_i2s;
        cand.period = POS_W'(b_d) * POS_W'(f_d);
        cand.lead   = LEAD_W'(p_d) + (raw_i2s ? LEAD_W'(b_d) : LEAD_W'(0));
    end
endmodule

// File: rtl/fcg_timebase.sv
`timescale 1ns/1ps
module fcg_timebase
    import fcg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  act_t cand,
    output tb_t  st_q,
    output tb_t  st_d
);
    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            if (en) begin
                st_d.run = 1'b1;
                st_d.pos = '0;
                st_d.cnt = '0;
                st_d.act = cand;
            end
        end else if (!en) begin
            st_d.run = 1'b0;
            st_d.pos = '0;
            st_d.cnt = '0;
        end else if (st_q.pos == st_q.act.period - POS_W'(1)) begin
            st_d.pos = '0;
            st_d.cnt = '0;
            st_d.act = cand;
        end else begin
            st_d.pos = st_q.pos + POS_W'(1);
            st_d.cnt = (st_q.cnt == st_q.act.bdiv - BDIV_W'(1)) ? '0
                                                                : st_q.cnt + BDIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fcg_wave.sv
`timescale 1ns/1ps
module fcg_wave
    import fcg_pkg::*;
(
    input  tb_t  st,
    output out_t wv
);
    localparam int HW = BDIV_W + 1;
    localparam int QW = POS_W + 1;

    logic [HW-1:0] hi_d;
    logic [QW-1:0] q_d;

    always_comb begin
        hi_d = ({1'b0, st.act.bdiv} + HW'(1)) >> 1;
        q_d  = {1'b0, st.pos} + QW'(st.act.lead);
        if (q_d >= {1'b0, st.act.period}) begin
            q_d = q_d - {1'b0, st.act.period};
        end
        wv      = '0;
        if (st.run) begin
            wv.bclk = ({1'b0, st.cnt} < hi_d);
            wv.fs   = (q_d >= {2'b00, st.act.period[POS_W-1:1]});
            wv.pass = (st.act.bdiv == BDIV_W'(1));
            wv.nc   = st.act.i2s && (st.act.bdiv == BDIV_W'(1));
        end
    end
endmodule

// File: rtl/frame_clock_gen.sv
`timescale 1ns/1ps
module frame_clock_gen
    import fcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [BDIV_W-1:0] cfg_bdiv,
    input  logic [FLEN_W-1:0] cfg_flen,
    input  logic [BDIV_W-1:0] cfg_phase,
    input  logic              cfg_i2s,
    output logic              bclk_o,
    output logic              fsync_o,
    output logic              nocomp_o
);
    act_t cand;
    tb_t  st_q;
    tb_t  st_d;
    out_t out_d;
    out_t out_q;
    logic bclk_q;

    fcg_cfg_clean u_clean (
        .raw_bdiv (cfg_bdiv),
        .raw_flen (cfg_flen),
        .raw_ph   (cfg_phase),
        .raw_i2s  (cfg_i2s),
        .cand     (cand)
    );

    fcg_timebase u_tb (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .cand (cand),
        .st_q (st_q),
        .st_d (st_d)
    );

    fcg_wave u_wave (
        .st (st_d),
        .wv (out_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign bclk_q   = out_q.bclk;
    assign bclk_o   = out_q.pass ? clk : out_q.bclk;
    assign fsync_o  = out_q.fs;
    assign nocomp_o = out_q.nc;
endmodule

// File: rtl/fcg_chk.sv
`timescale 1ns/1ps
module fcg_chk
    import fcg_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic en,
    input logic bclk_q,
    input logic fsync_o,
    input logic nocomp_o,
    input tb_t  st_q
);
    // R1
    stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!fsync_o && !bclk_q));

    // R2
    bclk_rise_at_bit_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bclk_q) |-> (st_q.cnt == '0));

    // R4
    pos_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.run |-> (st_q.pos < st_q.act.period));

    // R6
    lead_clamped_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.run |-> (st_q.act.ph < st_q.act.bdiv));

    // R9
    cfg_held_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.run && st_q.pos != '0) |-> $stable(st_q.act));

    // R8
    flag_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(nocomp_o) |-> (st_q.pos == '0));
endmodule

bind frame_clock_gen fcg_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .bclk_q   (bclk_q),
    .fsync_o  (fsync_o),
    .nocomp_o (nocomp_o),
    .st_q     (st_q)
);

// File: tb/sim_frame_clock_gen.sv
`timescale 1ns/1ps
module sim_frame_clock_gen;
    import fcg_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst = 1'b1;
    logic              en  = 1'b0;
    logic [BDIV_W-1:0] cfg_bdiv  = 6'd4;
    logic [FLEN_W-1:0] cfg_flen  = 8'd8;
    logic [BDIV_W-1:0] cfg_phase = '0;
    logic              cfg_i2s   = 1'b0;
    logic bclk_o, fsync_o, nocomp_o;

    frame_clock_gen u0 (
        .clk(clk), .rst(rst), .en(en),
        .cfg_bdiv(cfg_bdiv), .cfg_flen(cfg_flen),
        .cfg_phase(cfg_phase), .cfg_i2s(cfg_i2s),
        .bclk_o(bclk_o), .fsync_o(fsync_o), .nocomp_o(nocomp_o)
    );

    int n_run = 0;
    int n_fail = 0;
    string force_tag = "";

    int m_run = 0, m_pos = 0, m_bdiv = 1, m_flen = 2, m_ph = 0, m_i2s = 0;

    task automatic load_cfg();
        m_bdiv = (cfg_bdiv == 0) ? 1 : int'(cfg_bdiv);
        m_flen = int'(cfg_flen) & ~1;
        if (m_flen < 2) m_flen = 2;
        m_ph   = (int'(cfg_phase) >= m_bdiv) ? m_bdiv - 1 : int'(cfg_phase);
        m_i2s  = int'(cfg_i2s);
    endtask

    task automatic step();
        if (rst) begin
            m_run = 0; m_pos = 0;
        end else if (m_run == 0) begin
            if (en) begin load_cfg(); m_run = 1; m_pos = 0; end
        end else if (!en) begin
            m_run = 0; m_pos = 0;
        end else if (m_pos == m_bdiv * m_flen - 1) begin
            m_pos = 0; load_cfg();
        end else begin
            m_pos++;
        end
    endtask

    task automatic chk(string tag, logic got, logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b (t=%0t)", tag, got, exp, $time);
        end
    endtask

    task automatic check_all();
        int p, q;
        logic eb, ef, en_c;
        string tb_s, tf_s, tn_s;
        p = m_bdiv * m_flen;
        eb = 1'b0; ef = 1'b0; en_c = 1'b0;
        if (m_run != 0) begin
            eb = (m_bdiv == 1) ? 1'b0 : ((m_pos % m_bdiv) < (m_bdiv + 1) / 2);
            q  = (m_pos + m_ph + (m_i2s != 0 ? m_bdiv : 0)) % p;
            ef = (q >= p / 2);
            en_c = (m_i2s != 0) && (m_bdiv == 1);
        end
        tb_s = (m_run == 0) ? "R1" : (m_bdiv == 1 ? "R3" : "R2");
        tf_s = (m_run == 0) ? "R1" : (m_i2s != 0 ? "R7" : (m_ph != 0 ? "R5" : "R4"));
        tn_s = (m_run == 0) ? "R1" : "R8";
        if (force_tag != "") begin tb_s = force_tag; tf_s = force_tag; end
        chk(tb_s, bclk_o, eb);
        chk(tf_s, fsync_o, ef);
        chk(tn_s, nocomp_o, en_c);
    endtask

    task automatic adv(int n);
        for (int i = 0; i < n; i++) begin
            step();
            @(negedge clk);
            check_all();
        end
    endtask

    task automatic set_cfg(int b, int f, int ph, int i2);
        cfg_bdiv  = BDIV_W'(b);
        cfg_flen  = FLEN_W'(f);
        cfg_phase = BDIV_W'(ph);
        cfg_i2s   = i2[0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        // R1: reset state
        adv(4);
        rst = 1'b0;
        adv(3);
        // R2 R4: plain divide and frame
        set_cfg(4, 8, 0, 0); en = 1'b1;
        adv(80);
        // R5: lead of 2 master cycles (falling-edge alignment for D=4)
        set_cfg(4, 8, 2, 0);
        adv(100);
        // R6: lead above divisor clamps to D-1
        force_tag = "R6";
        set_cfg(4, 8, 9, 0);
        adv(100);
        force_tag = "";
        // R7: I2S framing with D=2, N=1
        set_cfg(2, 64, 1, 1);
        adv(300);
        // R3 R8: divide by 1 with I2S framing
        set_cfg(1, 64, 0, 1);
        adv(200);
        step();
        @(posedge clk); #1;
        chk("R3", bclk_o, 1'b1);
        @(negedge clk);
        check_all();
        // R9: mid-frame change must wait for the wrap
        set_cfg(4, 8, 0, 0);
        adv(100);
        adv(10);
        force_tag = "R9";
        set_cfg(2, 4, 1, 0);
        adv(40);
        force_tag = "";
        // R10: divisor 0 and odd frame length
        force_tag = "R10";
        set_cfg(0, 7, 3, 0);
        adv(60);
        set_cfg(3, 1, 0, 0);
        adv(60);
        force_tag = "";
        // R1: stop in mid-frame
        set_cfg(5, 6, 2, 0);
        adv(37);
        en = 1'b0;
        adv(5);
        en = 1'b1;
        adv(20);
        // random segments
        for (int s = 0; s < 150; s++) begin
            set_cfg($urandom % 7, $urandom % 13, $urandom % 8, $urandom % 2);
            en = (($urandom % 10) != 0);
            adv(20 + ($urandom % 200));
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule